// File: doc/BRIEF.md
# Clock Hold Objection Agent

This block is the device-side agent on a shared, resistor-pulled, active-low clock-run line. The host releases the line when it wants to slow or stop the bus clock. Any device that still needs the clock may pull the line low for a short time to object. The host then drives the line low itself until it next tries to stop the clock. If no device objects, the host is free to stop or slow the clock.

The agent runs whenever it is out of reset and has no enable bit. It samples the line through a flop synchroniser. Two consecutive high samples confirm that the host has released the line. If the clock-needed input is high at both decision edges, the agent turns on its open-drain pull for exactly two clocks and then releases it. A short hold-off follows, so the agent does not react to its own pull as it comes back through the synchroniser.

The agent never drives the line high. The clock-needed input is expected to be high whenever a USB device is attached or bus activity is pending.

Top module: `clk_hold_agent`

## Requirements
- R1: While rst_ni is low, run_line_pull_o is 0. The synchronised view of the line resets to low, so coming out of reset does not count as a confirmed release.
- R2: Let run_line_i be high at two consecutive rising edges k and k+1, and let clk_need_i be high at edges k+2 and k+3. Then run_line_pull_o goes to 1 on edge k+3, which is two clocks after the synchronised line first shows high.
- R3: Each pull lasts exactly 2 clock cycles. run_line_pull_o is 1 after edges k+3 and k+4 and 0 after edge k+5.
- R4: While clk_need_i is low, run_line_pull_o stays 0 however the line moves, so the host may stop the clock.
- R5: If run_line_i is high at only one rising edge between low samples, no pull follows.
- R6: If clk_need_i goes low at edge k+3, after the release has been confirmed but before the pull starts, the objection is cancelled and no pull follows.
- R7: Once a pull has started, it runs its full 2 cycles whatever clk_need_i or run_line_i do.
- R8: After a pull ends, the agent ignores the line for 2 cycles. Between two pulls, run_line_pull_o is low for at least 4 cycles. If the line stays released and clk_need_i stays high, the next pull starts 6 cycles after the previous one started.
- R9: run_line_pull_o only goes to 1 if run_line_i was high at the edges 2 and 3 cycles earlier. The agent never starts a pull while the host holds the line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_line_i | input | 1 | Level seen on the shared clock-run line (1 = released, pulled up) |
| clk_need_i | input | 1 | High while the device needs the bus clock |
| run_line_pull_o | output | 1 | Open-drain pull-low enable for the line (1 = drive low) |

## Verification
The agent is tried under several line patterns:
- A clean release that the host takes over at once, which fixes the three-edge latency and the two-cycle pulse width.
- A release the host never takes over, which tells the hold-off and repeat period apart from a one-shot design.
- A single-edge blip, which separates the two-sample confirmation from a bare edge detector.
- A line held low by the host with the clock needed, which checks that the agent never fights the host's drive.

Changes to clk_need_i are placed before confirmation, between confirmation and pull, and in the middle of a pull. These cases tell the cancel window apart from the committed pulse.

// File: rtl/clk_hold_pkg.sv
package clk_hold_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEEN = 2'd1,
    ST_PULL = 2'd2,
    ST_HOLD = 2'd3
  } agent_state_e;
endpackage

// File: rtl/clk_hold_sync.sv
module clk_hold_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q[0] <= RESET_VAL;
    else         q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[g] <= RESET_VAL;
      else         q[g] <= q[g-1];
    end
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/clk_hold_fsm.sv
module clk_hold_fsm
  import clk_hold_pkg::*;
#(
  parameter int unsigned PULL_CYCLES = 2,
  parameter int unsigned HOLD_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_hi_i,
  input  logic need_i,
  output logic pull_o
);
  localparam int unsigned MAX_CYC = (PULL_CYCLES > HOLD_CYCLES) ? PULL_CYCLES : HOLD_CYCLES;
  localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] PULL_LOAD = CNT_W'(PULL_CYCLES - 1);
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYCLES - 1);

  agent_state_e     state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pull_q;
  logic             object;

  assign object = line_hi_i & need_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (object) state_d = ST_SEEN;
      ST_SEEN: begin
        if (object) begin
          state_d = ST_PULL;
          cnt_d   = PULL_LOAD;
        end else begin
          state_d = ST_IDLE;
        end
      end
      // committed: pulse runs to completion regardless of inputs
      ST_PULL: begin
        if (cnt_q == '0) begin
          state_d = ST_HOLD;
          cnt_d   = HOLD_LOAD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      // hold-off while own pull drains through the synchroniser
      ST_HOLD: begin
        if (cnt_q == '0) state_d = ST_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pull_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pull_q  <= (state_d == ST_PULL);
    end
  end

  assign pull_o = pull_q;
endmodule

// File: rtl/clk_hold_agent.sv
module clk_hold_agent #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PULL_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_line_i,
  input  logic clk_need_i,
  output logic run_line_pull_o
);
  localparam int unsigned HOLD_CYCLES = SYNC_STAGES;

  logic line_hi;

  clk_hold_sync #(
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (1'b0)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (run_line_i),
    .q_o    (line_hi)
  );

  clk_hold_fsm #(
    .PULL_CYCLES (PULL_CYCLES),
    .HOLD_CYCLES (HOLD_CYCLES)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_hi_i (line_hi),
    .need_i    (clk_need_i),
    .pull_o    (run_line_pull_o)
  );
endmodule

// File: rtl/clk_hold_agent_chk.sv
module clk_hold_agent_chk #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PULL_CYCLES = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic run_line_i,
  input logic clk_need_i,
  input logic run_line_pull_o
);
  localparam int unsigned MIN_GAP = SYNC_STAGES + 2;

  logic [7:0] gap_cnt;
  logic       had_pull;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_cnt  <= '0;
      had_pull <= 1'b0;
    end else if (run_line_pull_o) begin
      gap_cnt  <= '0;
      had_pull <= 1'b1;
    end else if (gap_cnt != 8'hff) begin
      gap_cnt  <= gap_cnt + 8'd1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) !rst_ni |-> !run_line_pull_o);

  // R9
  line_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_line_pull_o) |-> ($past(run_line_i, 3) && $past(run_line_i, 4)));

  // R4
  need_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_line_pull_o) |-> ($past(clk_need_i, 1) && $past(clk_need_i, 2)));

  // R3
  pulse_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_line_pull_o) |=> run_line_pull_o);

  // R3
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_line_pull_o) |-> ($past(run_line_pull_o, 1) && $past(run_line_pull_o, 2)
                                && !$past(run_line_pull_o, 3)));

  // R8
  gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(run_line_pull_o) && had_pull) |-> (gap_cnt >= 8'(MIN_GAP)));
endmodule

bind clk_hold_agent clk_hold_agent_chk #(
  .SYNC_STAGES (SYNC_STAGES),
  .PULL_CYCLES (PULL_CYCLES)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .run_line_i      (run_line_i),
  .clk_need_i      (clk_need_i),
  .run_line_pull_o (run_line_pull_o)
);

// File: tb/clk_hold_agent_test.sv
`timescale 1ns/1ps
module clk_hold_agent_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic host_low = 1'b1;
  logic need = 1'b0;
  logic pull;
  logic run_line;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  assign run_line = ~(host_low | pull);

  clk_hold_agent uut (
    .clk_i           (clk),
    .rst_ni          (rst_ni),
    .run_line_i      (run_line),
    .clk_need_i      (need),
    .run_line_pull_o (pull)
  );

  task automatic check(input bit act, input bit exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: pull=%0b expected %0b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // reference model: two-sample line history, confirm flag, pulse-plus-holdoff countdown
  bit m_s1, m_s2, armed, exp_pull;
  int left;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_s1 = 0; m_s2 = 0; armed = 0; left = 0; exp_pull = 0;
    end else begin
      automatic bit hi = m_s2;
      cyc++;
      if (left > 0) begin
        left--;
        exp_pull = (left > 2);
      end else if (armed) begin
        armed = 0;
        if (hi && need) begin left = 4; exp_pull = 1; end
      end else if (hi && need) begin
        armed = 1;
      end
      m_s2 = m_s1;
      m_s1 = run_line;
    end
  end

  always @(negedge clk) if (rst_ni && !done) check(pull, exp_pull, cur_req);

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    step(100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not end, actual running expected done");
    finish_run();
  end

  initial begin
    #1 rst_ni = 1'b0;
    step(3);
    check(pull, 1'b0, "R1");
    #2 rst_ni = 1'b1;
    step(4);
    check(pull, 1'b0, "R1");

    // R2 R3: clean release, host takes over once pull seen
    cur_req = "R2";
    need = 1'b1;
    host_low = 1'b0;
    step(3); check(pull, 1'b0, "R2");
    step(1); check(pull, 1'b1, "R2");
    host_low = 1'b1;
    step(1); check(pull, 1'b1, "R3");
    step(1); check(pull, 1'b0, "R3");
    step(8);

    // R4: no need, line released for a long time
    cur_req = "R4";
    need = 1'b0;
    host_low = 1'b0;
    step(12); check(pull, 1'b0, "R4");
    host_low = 1'b1;
    step(6);

    // R5: one-edge blip
    cur_req = "R5";
    need = 1'b1;
    host_low = 1'b0;
    step(1);
    host_low = 1'b1;
    step(8); check(pull, 1'b0, "R5");

    // R6: need withdrawn in the confirm window
    cur_req = "R6";
    host_low = 1'b0;
    step(3);
    need = 1'b0;
    host_low = 1'b1;
    step(1); check(pull, 1'b0, "R6");
    step(6); check(pull, 1'b0, "R6");

    // R7: need dropped and host takes over mid-pulse
    cur_req = "R7";
    need = 1'b1;
    host_low = 1'b0;
    step(4); check(pull, 1'b1, "R7");
    need = 1'b0;
    host_low = 1'b1;
    step(1); check(pull, 1'b1, "R7");
    step(1); check(pull, 1'b0, "R7");
    step(8);

    // R8: host never takes over, objection repeats every 6 cycles
    cur_req = "R8";
    need = 1'b1;
    host_low = 1'b0;
    step(4); check(pull, 1'b1, "R8");
    step(5); check(pull, 1'b0, "R8");
    step(1); check(pull, 1'b1, "R8");
    step(6); check(pull, 1'b1, "R8");
    host_low = 1'b1;
    step(10);

    // R9: host holds the line low while clock is needed
    cur_req = "R9";
    need = 1'b1;
    host_low = 1'b1;
    step(12); check(pull, 1'b0, "R9");

    finish_run();
  end
endmodule